// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block recovers characters from an asynchronous serial line. A free-running enable pulse at sixteen times the bit rate paces an internal sampler. A falling edge on the idle (mark) line starts a start-bit check. If the start bit is confirmed, the sampler takes each data bit once at its centre. Each data bit is shifted into an assembly register, least significant bit first. The character length is programmable from five to eight bits.

After the stop bit's centre sample, the assembled character is copied into a receive buffer and a data-ready flag goes high. The host reads the character from an 8-bit read port and acknowledges it with a one-cycle read strobe. A single error flag records that a character was overwritten before the host collected it.

For self-test, a loop mode feeds the receiver from the local transmitter's serial output. In this mode the external line is not listened to.

Top module: `serial_rx_unit`

## Requirements
- R1: Data bits arrive least significant bit first: the first bit after the start bit lands in `rdData[0]`. A high line level (mark) is received as 1 and a low level (space) as 0.
- R2: In idle, a low sample on a tick begins a start check. The start is accepted only if the line is still low on the 8th tick after that sample. Otherwise the receiver returns to idle and produces no character.
- R3: `charLen` selects the character length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. The value is captured when the start bit is accepted. Successive data bits are sampled 16 ticks apart.
- R4: `dataReady` rises only after the stop bit is sampled, 16 ticks after the last data bit. At that moment the buffer is loaded. Before then, `dataReady` stays low.
- R5: A one-cycle `rdStrobe` clears `dataReady` on the next clock. The exception is a read in the same cycle as a buffer load: then `dataReady` stays set. Without a load, the buffer keeps its value.
- R6: For lengths below 8 bits, the bits of `rdData` above the character length read as 0.
- R7: While `loopEn` is 1, the receiver takes its input from `loopTxBit` and ignores `serialIn`.
- R8: While `rst` is 1, the receiver is held idle and `serialIn` has no effect. When reset is released, `dataReady`, `overrun` and `rdData` are all 0.
- R9: A character that completes while `dataReady` is still set overwrites the buffer and sets `overrun`. `overrun` is cleared by `rdStrobe` or by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | One-cycle pulse at 16x the bit rate |
| serialIn | input | 1 | External serial line (mark = 1) |
| loopEn | input | 1 | Selects the local transmitter stream as input |
| loopTxBit | input | 1 | Serial output of the local transmitter |
| charLen | input | 2 | Character length select (5 to 8 bits) |
| rdStrobe | input | 1 | Host read acknowledge of the buffer |
| rdData | output | 8 | Received character, zero-extended |
| dataReady | output | 1 | A character waits in the buffer |
| overrun | output | 1 | A character was overwritten before being read |

## Verification
Two cases are hard to reach from the ports: a start that is rejected, and an overwrite of an unread character. Both depend on timing against the free-running tick rather than on data values.

For the rejected start, the bench drives a low pulse four ticks long. It then shows that no character appears and that a following valid frame is still received correctly.

For the overwrite, the bench sends two complete frames back to back without reading. It then checks that the second character replaced the first and that the error flag clears on the next read.

In the loop-mode vectors, the external line is held at space for the whole frame. A receiver that listened to it would therefore assemble the wrong value.

// File: rtl/rx_pkg.sv
package rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic loadBuf;
  } rxStrobe_t;

endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int TICKS   = 16,
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int SEL_W   = 2,
  parameter int LEN_W   = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tickEn,
  input  logic             rxBit,
  input  logic [SEL_W-1:0] charLen,
  output rxStrobe_t        strb,
  output logic [LEN_W-1:0] frameLen
);

  localparam int CNT_W = $clog2(TICKS);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(TICKS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TICKS - 1);

  rxState_e         state;
  logic [CNT_W-1:0] tickCnt;
  logic [LEN_W-1:0] bitIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      tickCnt  <= '0;
      bitIdx   <= '0;
      frameLen <= LEN_W'(DATA_W);
    end else if (tickEn) begin
      case (state)
        RX_IDLE: begin
          if (!rxBit) begin
            state   <= RX_START;
            tickCnt <= '0;
          end
        end
        RX_START: begin
          if (tickCnt == MID_CNT) begin
            tickCnt <= '0;
            if (!rxBit) begin
              state    <= RX_DATA;
              bitIdx   <= '0;
              frameLen <= LEN_W'(MIN_LEN) + LEN_W'(charLen);
            end else begin
              state <= RX_IDLE;
            end
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            if (bitIdx == frameLen - 1'b1) state <= RX_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            state   <= RX_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.shiftEn = tickEn && (state == RX_DATA) && (tickCnt == LAST_CNT);
    strb.loadBuf = tickEn && (state == RX_STOP) && (tickCnt == LAST_CNT);
  end

  // R2: a high line in idle never starts a frame
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (state == RX_IDLE && tickEn && rxBit) |=> (state == RX_IDLE));

  // R2: a start that is high at mid-bit is rejected
  assert_start_reject_R2: assert property (@(posedge clk) disable iff (rst)
    (state == RX_START && tickEn && tickCnt == MID_CNT && rxBit) |=> (state == RX_IDLE));

  // R3: the buffer is loaded only after exactly frameLen data bits
  assert_bit_count_R3: assert property (@(posedge clk) disable iff (rst)
    strb.loadBuf |-> (bitIdx == frameLen - 1'b1));

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.shiftEn, strb.loadBuf}));

endmodule

// File: rtl/rx_data.sv
module rx_data
  import rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serialIn,
  input  logic              loopEn,
  input  logic              loopTxBit,
  input  rxStrobe_t         strb,
  input  logic [LEN_W-1:0]  frameLen,
  input  logic              rdStrobe,
  output logic              rxBit,
  output logic [DATA_W-1:0] rdData,
  output logic              dataReady,
  output logic              overrun
);

  logic              syncOut;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] rxBuf;

  generate
    if (SYNC_STAGES == 0) begin : g_noSync
      assign syncOut = serialIn;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] syncChain;
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '1;
        else if (SYNC_STAGES == 1) syncChain <= serialIn;
        else syncChain <= {syncChain[SYNC_STAGES-2:0], serialIn};
      end
      assign syncOut = syncChain[SYNC_STAGES-1];
    end
  endgenerate

  assign rxBit = loopEn ? loopTxBit : syncOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg  <= '0;
      rxBuf     <= '0;
      dataReady <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (strb.shiftEn) shiftReg <= {rxBit, shiftReg[DATA_W-1:1]};
      if (strb.loadBuf) rxBuf <= shiftReg >> (LEN_W'(DATA_W) - frameLen);
      if (strb.loadBuf) dataReady <= 1'b1;
      else if (rdStrobe) dataReady <= 1'b0;
      if (strb.loadBuf && dataReady && !rdStrobe) overrun <= 1'b1;
      else if (rdStrobe) overrun <= 1'b0;
    end
  end

  assign rdData = rxBuf;

  // R5: a read without a simultaneous load clears the flag
  assert_ready_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && !strb.loadBuf) |=> !dataReady);

  // R5: the buffer only changes on a load
  assert_buf_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !strb.loadBuf |=> $stable(rdData));

  // R9: overrun only rises when an unread character was pending
  assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(dataReady));

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import rx_pkg::*;
#(
  parameter int TICKS       = 16,
  parameter int DATA_W      = 8,
  parameter int MIN_LEN     = 5,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              serialIn,
  input  logic              loopEn,
  input  logic              loopTxBit,
  input  logic [SEL_W-1:0]  charLen,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  output logic              dataReady,
  output logic              overrun
);

  localparam int LEN_W = $clog2(DATA_W + 1);

  rxStrobe_t        strb;
  logic [LEN_W-1:0] frameLen;
  logic             rxBit;

  rx_ctrl #(
    .TICKS(TICKS), .DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .SEL_W(SEL_W), .LEN_W(LEN_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .tickEn(tickEn), .rxBit(rxBit),
    .charLen(charLen), .strb(strb), .frameLen(frameLen)
  );

  rx_data #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .LEN_W(LEN_W)
  ) i_data (
    .clk(clk), .rst(rst), .serialIn(serialIn), .loopEn(loopEn),
    .loopTxBit(loopTxBit), .strb(strb), .frameLen(frameLen),
    .rdStrobe(rdStrobe), .rxBit(rxBit), .rdData(rdData),
    .dataReady(dataReady), .overrun(overrun)
  );

  // R4: data-ready rises only from a stop-bit load
  assert_ready_source_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dataReady) |-> $past(strb.loadBuf));

  // R6: bits above the captured length are zero after a load
  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    strb.loadBuf |=> ((rdData >> $past(frameLen)) == '0));

endmodule

// File: tb/test_serial_rx_unit.sv
module test_serial_rx_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickEn;
  logic       serialIn = 1'b1;
  logic       loopEn = 1'b0;
  logic       loopTxBit = 1'b1;
  logic [1:0] charLen = 2'b11;
  logic       rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic       dataReady;
  logic       overrun;
  logic [1:0] tickDiv = 2'd0;
  int checkCount = 0;
  int failCount = 0;
  bit doneFlag = 1'b0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) tickDiv <= tickDiv + 2'd1;
  assign tickEn = (tickDiv == 2'd3);

  serial_rx_unit i_serial_rx_unit (
    .clk(clk), .rst(rst), .tickEn(tickEn), .serialIn(serialIn),
    .loopEn(loopEn), .loopTxBit(loopTxBit), .charLen(charLen),
    .rdStrobe(rdStrobe), .rdData(rdData), .dataReady(dataReady),
    .overrun(overrun)
  );

  // {charLen, viaLoop, sent, expected}
  localparam logic [18:0] VEC [6] = '{
    {2'b11, 1'b0, 8'hA5, 8'hA5},
    {2'b00, 1'b0, 8'hFF, 8'h1F},
    {2'b01, 1'b0, 8'hC3, 8'h03},
    {2'b10, 1'b0, 8'hD6, 8'h56},
    {2'b11, 1'b1, 8'h3C, 8'h3C},
    {2'b00, 1'b1, 8'h0A, 8'h0A}
  };

  task automatic check(input string req, input int actual, input int expected);
    checkCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setLine(input bit viaLoop, input bit b);
    if (viaLoop) loopTxBit = b;
    else serialIn = b;
  endtask

  // one bit time = 16 ticks = 64 clocks
  task automatic sendFrame(input logic [7:0] d, input logic [1:0] len,
                           input bit viaLoop, input bit probe);
    @(negedge clk);
    charLen = len;
    if (viaLoop) begin
      loopEn = 1'b1;
      serialIn = 1'b0;  // external line held at space: must be ignored (R7)
    end
    setLine(viaLoop, 1'b0);
    waitClk(64);
    for (int i = 0; i < 5 + int'(len); i++) begin
      setLine(viaLoop, d[i]);
      waitClk(64);
    end
    setLine(viaLoop, 1'b1);
    if (probe) begin
      waitClk(16);
      check("R4 ready low before stop sample", dataReady, 0);
      waitClk(48);
    end else begin
      waitClk(64);
    end
    waitClk(16);
    if (viaLoop) begin
      serialIn = 1'b1;
      waitClk(8);
      loopEn = 1'b0;
      waitClk(8);
    end
  endtask

  task automatic readBuf();
    @(negedge clk) rdStrobe = 1'b1;
    @(negedge clk) rdStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    waitClk(5);
    // R8: a full frame on serialIn during reset is not received
    sendFrame(8'h5A, 2'b11, 1'b0, 1'b0);
    @(negedge clk) rst = 1'b0;
    waitClk(4);
    check("R8 dataReady after reset", dataReady, 0);
    check("R8 overrun after reset", overrun, 0);
    check("R8 rdData after reset", rdData, 0);

    // table of frames: R1 R3 R6 R7 R5
    for (int v = 0; v < 6; v++) begin
      sendFrame(VEC[v][15:8], VEC[v][18:17], VEC[v][16], v == 0);
      check("R4 dataReady after frame", dataReady, 1);
      check("R1_R3_R6_R7 received character", rdData, VEC[v][7:0]);
      readBuf();
      check("R5 dataReady cleared by read", dataReady, 0);
      check("R5 buffer held after read", rdData, VEC[v][7:0]);
    end

    // R2: a short low glitch is rejected
    @(negedge clk) serialIn = 1'b0;
    waitClk(16);
    serialIn = 1'b1;
    waitClk(200);
    check("R2 glitch produces no character", dataReady, 0);
    sendFrame(8'h55, 2'b11, 1'b0, 1'b0);
    check("R2 frame after glitch", rdData, 8'h55);
    check("R2 ready after glitch frame", dataReady, 1);
    readBuf();

    // R9: overwrite of an unread character
    sendFrame(8'h11, 2'b11, 1'b0, 1'b0);
    check("R9 no overrun on first", overrun, 0);
    sendFrame(8'h22, 2'b11, 1'b0, 1'b0);
    check("R9 overrun set", overrun, 1);
    check("R9 buffer overwritten", rdData, 8'h22);
    readBuf();
    check("R9 overrun cleared by read", overrun, 0);
    check("R5 ready cleared after overrun read", dataReady, 0);

    doneFlag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule